// File: doc/BRIEF.md
# Quantum Round-Robin Task Selector

This block picks which of four task slots owns the processor. Slot 0 is the idle slot and is selected out of reset. Slots 1 to 3 are user tasks, each with a runnable flag driven from outside. A periodic tick, nominally one pulse every 10 ms, counts down the time slice of the task that is running. When the slice is used up, the counter is reloaded with the full slice length and the next runnable user task in circular order takes over.

The search for a successor starts at the slot after the current one and wraps through slots 1, 2 and 3. The current task is considered last, so it keeps the processor only when no other user task can run. When no user task is runnable, the idle slot is selected. A task can give up its slice early with a single-cycle yield pulse. A task whose runnable flag drops is replaced at once. The outputs are the selected slot index, a one-cycle strobe for each change of selection, and the number of ticks left in the current slice. Context saving and interrupt control belong to other logic.

Top module: `quantum_rr_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `cur_slot` is 0, `switch_pulse` is 0 and `slice_left` equals SLICE.
- R2: A tick that does not cause a reschedule lowers `slice_left` by exactly one. In a cycle with no tick and no reschedule, `slice_left` keeps its value. `slice_left` never reads 0.
- R3: A tick that arrives while `slice_left` is 1 reloads `slice_left` to SLICE and triggers a reschedule at the same clock edge.
- R4: A reschedule selects the first slot whose `run_ok` bit is 1, scanning from the slot after the current one through user slots 1, 2, 3 with wrap-around. The current slot is scanned last. Bit k of `run_ok` is the flag of slot k.
- R5: When every `run_ok` bit is 0, a reschedule selects slot 0.
- R6: When the current user slot is the only runnable one, an expiry leaves it selected, reloads `slice_left` to SLICE and keeps `switch_pulse` at 0.
- R7: A yield pulse causes a reschedule at the next edge, and the selected task starts with `slice_left` equal to SLICE.
- R8: If the current user slot's `run_ok` bit is 0, or slot 0 is current while any `run_ok` bit is 1, a reschedule happens at the next edge without waiting for a tick or a yield.
- R9: A tick and a yield in the same cycle cause a single reschedule. Selection advances by one search and `slice_left` becomes SLICE, with no tick applied on top.
- R10: `switch_pulse` is 1 for exactly the cycles in which `cur_slot` differs from its value one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Single-cycle time-base pulse (one per 10 ms) |
| yield_req | input | 1 | Single-cycle pulse: current task gives up its slice |
| run_ok | input | NSLOT-1 | Runnable flags of user slots 1..NSLOT-1, bit k for slot k |
| cur_slot | output | $clog2(NSLOT) | Index of the selected slot |
| switch_pulse | output | 1 | High for the one cycle in which the selection has just changed |
| slice_left | output | $clog2(SLICE+1) | Ticks remaining in the current slice |

## Verification
The hardest situations to reach are the ones where several triggers meet in one cycle. Examples are a tick landing on the last slice tick together with a yield, or a runnable flag dropping in that same cycle. The sole-runnable expiry, where the slot must hold without a strobe, is also hard to reach. The stimulus first drives each of these directly. It then sweeps every runnable pattern against every tick/yield combination for a run of cycles, so each pattern is met from every current slot and at every slice count. A bench-side arithmetic model of the circular scan predicts slot, strobe and count each cycle.

// File: rtl/qrr_pkg.sv
package qrr_pkg;

    typedef enum logic [1:0] {
        WHY_NONE       = 2'd0,
        WHY_EXPIRE     = 2'd1,
        WHY_YIELD      = 2'd2,
        WHY_INELIGIBLE = 2'd3
    } resched_why_e;

endpackage

// File: rtl/qrr_next_pick.sv
module qrr_next_pick #(
    parameter int NSLOT = 4,
    localparam int SW = $clog2(NSLOT),
    localparam int NU = NSLOT - 1
) (
    input  logic [SW-1:0]    cur,
    input  logic [NSLOT-1:1] run_ok,
    output logic [SW-1:0]    pick
);

    logic [SW-1:0] base;
    logic [SW-1:0] cand [1:NU];
    logic [NU:1]   hit;

    // base is chosen so that base+1 (mod NU) + 1 is the slot after cur
    assign base = (cur == '0) ? SW'(NU - 1) : (cur - 1'b1);

    for (genvar g = 1; g <= NU; g++) begin : g_cand
        logic [SW:0] sum;
        logic [SW:0] red;
        assign sum = {1'b0, base} + (SW+1)'(g);
        assign red = (sum >= (SW+1)'(NU)) ? (sum - (SW+1)'(NU)) : sum;
        assign cand[g] = SW'(red + 1'b1);
        assign hit[g]  = run_ok[cand[g]];
    end

    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = 1; i <= NU; i++) begin
            if (!found && hit[i]) begin
                pick  = cand[i];
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/qrr_slice_ctr.sv
module qrr_slice_ctr #(
    parameter int SLICE = 5,
    localparam int CW = $clog2(SLICE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          reload,
    output logic [CW-1:0] count,
    output logic          expire
);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (reload)    count_d = CW'(SLICE);
        else if (tick) count_d = count_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= CW'(SLICE);
        else        count_q <= count_d;
    end

    assign count  = count_q;
    assign expire = tick && (count_q == CW'(1));

    p_tick_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload) |=> (count_q == CW'($past(count_q) - 1'b1)));
    p_never_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q != '0);
    p_reload_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (count_q == CW'(SLICE)));

endmodule

// File: rtl/qrr_cause.sv
module qrr_cause
    import qrr_pkg::*;
#(
    parameter int NSLOT = 4,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    cur,
    input  logic [NSLOT-1:1] run_ok,
    input  logic             tick,
    input  logic             yield_req,
    input  logic             expire,
    output logic             resched
);

    logic         eligible;
    resched_why_e why;

    // idle slot is eligible only while no user slot can run
    assign eligible = (cur == '0) ? ~|run_ok : run_ok[cur];

    always_comb begin
        why = WHY_NONE;
        if (!eligible)      why = WHY_INELIGIBLE;
        else if (yield_req) why = WHY_YIELD;
        else if (expire)    why = WHY_EXPIRE;
    end

    assign resched = (why != WHY_NONE);

    p_yield_acts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        yield_req |-> resched);
    p_expire_acts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && expire) |-> resched);

endmodule

// File: rtl/quantum_rr_sched.sv
module quantum_rr_sched #(
    parameter int NSLOT = 4,
    parameter int SLICE = 5,
    localparam int SW = $clog2(NSLOT),
    localparam int CW = $clog2(SLICE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             yield_req,
    input  logic [NSLOT-1:1] run_ok,
    output logic [SW-1:0]    cur_slot,
    output logic             switch_pulse,
    output logic [CW-1:0]    slice_left
);

    typedef struct packed {
        logic [SW-1:0] cur;
        logic          pulse;
    } sel_t;

    sel_t          sel_d, sel_q;
    logic [SW-1:0] pick;
    logic          expire;
    logic          resched;

    qrr_next_pick #(.NSLOT(NSLOT)) u_pick (
        .cur    (sel_q.cur),
        .run_ok (run_ok),
        .pick   (pick)
    );

    qrr_slice_ctr #(.SLICE(SLICE)) u_slice (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .reload (resched),
        .count  (slice_left),
        .expire (expire)
    );

    qrr_cause #(.NSLOT(NSLOT)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (sel_q.cur),
        .run_ok    (run_ok),
        .tick      (tick),
        .yield_req (yield_req),
        .expire    (expire),
        .resched   (resched)
    );

    always_comb begin
        sel_d       = sel_q;
        sel_d.pulse = 1'b0;
        if (resched) begin
            sel_d.cur   = pick;
            sel_d.pulse = (pick != sel_q.cur);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '{cur: '0, pulse: 1'b0};
        else        sel_q <= sel_d;
    end

    assign cur_slot     = sel_q.cur;
    assign switch_pulse = sel_q.pulse;

    p_pulse_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        switch_pulse == (cur_slot != $past(cur_slot)));
    p_pick_runnable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resched && pick != '0) |-> run_ok[pick]);
    p_idle_when_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resched && run_ok == '0) |-> (pick == '0));

endmodule

// File: tb/sim_quantum_rr_sched.sv
module sim_quantum_rr_sched;

    localparam int NSLOT = 4;
    localparam int SLICE = 5;
    localparam int SW = $clog2(NSLOT);
    localparam int CW = $clog2(SLICE + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             yield_req = 1'b0;
    logic [NSLOT-1:1] run_ok = '0;
    logic [SW-1:0]    cur_slot;
    logic             switch_pulse;
    logic [CW-1:0]    slice_left;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_cur = 0;
    int m_sl = SLICE;
    int m_pulse = 0;

    always #4 clk = ~clk;

    quantum_rr_sched #(.NSLOT(NSLOT), .SLICE(SLICE)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .yield_req    (yield_req),
        .run_ok       (run_ok),
        .cur_slot     (cur_slot),
        .switch_pulse (switch_pulse),
        .slice_left   (slice_left)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // one cycle: drive at negedge, predict, compare just after the edge
    task automatic step(input bit t, input bit y, input logic [NSLOT-1:1] r);
        bit    elig;
        bit    re;
        int    nxt;
        string tag;
        @(negedge clk);
        tick = t; yield_req = y; run_ok = r;
        elig = (m_cur == 0) ? (r == 0) : r[m_cur];
        re   = !elig || y || (t && m_sl == 1);
        tag  = "R2";
        if (re) begin
            nxt = 0;
            for (int k = 1; k <= NSLOT - 1; k++) begin
                int s;
                s = ((m_cur + k - 1) % (NSLOT - 1)) + 1;
                if (nxt == 0 && r[s]) nxt = s;
            end
            if (!elig)              tag = "R8";
            else if (t && y)        tag = "R9";
            else if (y)             tag = "R7";
            else if (r == 0)        tag = "R5";
            else if (nxt == m_cur)  tag = "R6";
            else                    tag = "R3";
            m_pulse = (nxt != m_cur);
            m_cur   = nxt;
            m_sl    = SLICE;
        end else begin
            m_pulse = 0;
            if (t) m_sl = m_sl - 1;
        end
        @(posedge clk);
        #1;
        check(re ? "R4" : tag, "cur_slot", int'(cur_slot), m_cur);
        check(tag, "slice_left", int'(slice_left), m_sl);
        check("R10", "switch_pulse", int'(switch_pulse), m_pulse);
        tick = 1'b0; yield_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "cur_slot in reset", int'(cur_slot), 0);
        check("R1", "slice_left in reset", int'(slice_left), SLICE);
        check("R1", "switch_pulse in reset", int'(switch_pulse), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // idle: nothing runnable, ticks wrap the idle slice (R5, R2)
        for (int i = 0; i < 12; i++) step(i % 2 == 0, 1'b0, 3'b000);
        // all runnable: leave idle at once (R8), then rotate by expiry (R3, R4)
        step(1'b0, 1'b0, 3'b111);
        for (int i = 0; i < 3 * SLICE + 2; i++) step(1'b1, 1'b0, 3'b111);
        // yield mid-slice (R7)
        step(1'b1, 1'b0, 3'b111);
        step(1'b0, 1'b1, 3'b111);
        // count down to 1, then tick and yield together (R9)
        for (int i = 0; i < SLICE - 1; i++) step(1'b1, 1'b0, 3'b111);
        step(1'b1, 1'b1, 3'b111);
        // only slot 2 runnable: move there, then expire in place (R6)
        step(1'b0, 1'b0, 3'b010);
        for (int i = 0; i < 2 * SLICE; i++) step(1'b1, 1'b0, 3'b010);
        step(1'b0, 1'b1, 3'b010);
        // drop the current flag, then drop all (R8, R5)
        step(1'b0, 1'b0, 3'b101);
        step(1'b1, 1'b0, 3'b100);
        step(1'b0, 1'b0, 3'b000);

        // sweep every pattern against every tick/yield combination
        for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 4; c++) begin
                for (int n = 0; n < 3 * SLICE; n++) begin
                    step(c[0] | (n % 3 == 0), c[1] & (n % 4 == 1), 3'(p));
                end
            end
        end

        // pseudo-random stretch with slowly changing flags
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            logic [NSLOT-1:1] r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r = (n % 16 < 12) ? 3'b111 & (lfsr[15:13] | 3'(n / 64 % 8)) : lfsr[2:0];
            step(lfsr[4] | lfsr[5], lfsr[6] & lfsr[7] & lfsr[8], r);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule